// File: doc/BRIEF.md
# Time-Slotted Processing-Element Scheduler

This block sequences a small array of finite-field processing elements (PEs) that share a bank of coefficient registers. The bank holds `NUM_REG` registers (2t in coding terms). It is cut into `NUM_PE` equal segments of `SEG = NUM_REG/NUM_PE` registers. Each PE owns exactly one segment. It reads that segment through a SEG-to-1 select and writes it back through a 1-to-SEG write-enable fan-out.

A single slot counter drives all of the control. The active mode sets how many PEs work at the same time: one, two, or all of them. An iteration visits every register exactly once. It therefore lasts `NUM_REG` slots with one PE, `NUM_REG/2` slots with two, and `SEG` slots with all PEs. Fewer active PEs means lower throughput and fewer toggling datapaths.

A mode change is requested with a strobe. It takes effect only between iterations. The PE arithmetic lies outside this block, which produces only the per-PE select, the per-register write enables, the per-PE active flags and an end-of-iteration pulse.

Top module: `pe_slot_sched`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `slot` is 0, `mode_cur` is 2'b00 (one PE) and `iter_done` is 0.
- R2: PE k asserts write enables only inside its own segment, at register index k*SEG+j. Here j = `slot` mod SEG, and the same j appears on that PE's `pe_sel` field (bits k*SEG_AW and up).
- R3: In mode 2'b00 PE k is active in slots k*SEG to (k+1)*SEG-1, no other PE is active in those slots, and an iteration lasts NUM_REG slots.
- R4: In mode 2'b01 the active PEs in a slot are those with k mod (NUM_PE/2) equal to slot/SEG. For four PEs, PE0 and PE2 run first, then PE1 and PE3. An iteration lasts NUM_REG/2 slots.
- R5: In mode 2'b10 every PE is active in every running slot, and an iteration lasts SEG slots.
- R6: Every register receives exactly one write enable per iteration, in every mode.
- R7: `iter_done` is high for exactly the one cycle that is the last slot of an iteration while `run` is high. The next slot is 0.
- R8: Mode codes are 2'b00 (one PE), 2'b01 (two PEs) and 2'b10 (all PEs). A strobe carrying 2'b11 is ignored.
- R9: A mode strobe is held pending and applied only at an iteration boundary. A boundary is the clock edge that ends a `iter_done` cycle, or any edge while `run` is low and `slot` is 0. When several strobes arrive, the latest legal one wins.
- R10: While `run` is low, `slot` holds its value, every write enable and active flag is 0, and no iteration completes.
- R11: An idle PE drives 0 on its `pe_sel` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance one slot per cycle when high |
| mode_wr | input | 1 | Strobe that captures `mode_req` as the pending mode |
| mode_req | input | 2 | Requested mode code |
| mode_cur | output | 2 | Mode in force for the current iteration |
| slot | output | $clog2(NUM_REG) | Slot index within the iteration |
| pe_active | output | NUM_PE | Per-PE active flag |
| pe_sel | output | NUM_PE*SEG_AW | Per-PE register select within its segment |
| reg_we | output | NUM_REG | Per-register write enable |
| iter_done | output | 1 | Pulse on the last slot of an iteration |

## Verification
Only the slot counter and the two mode registers hold state, so a wrong value in any of them is visible at the ports at once. A slot off by one moves a write enable to the wrong register in the same cycle. A mode applied early changes the width of `pe_active` before the pulse on `iter_done` that should precede it. A missed wrap leaves a register written twice, or never, within one iteration. The bench therefore compares every output on every cycle with a model built from the requirements. It also counts the writes per register between pulses, so a mistake shows up no later than the end of the iteration in which it happens.

// File: rtl/pe_slot_sched.sv
module pe_slot_sched #(
  parameter int NUM_PE  = 4,
  parameter int NUM_REG = 16,
  localparam int SEG    = NUM_REG / NUM_PE,
  localparam int SEG_AW = $clog2(SEG),
  localparam int SLOT_W = $clog2(NUM_REG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     mode_wr,
  input  logic [1:0]               mode_req,
  output logic [1:0]               mode_cur,
  output logic [SLOT_W-1:0]        slot,
  output logic [NUM_PE-1:0]        pe_active,
  output logic [NUM_PE*SEG_AW-1:0] pe_sel,
  output logic [NUM_REG-1:0]       reg_we,
  output logic                     iter_done
);

  logic [1:0]        pend_q, pend_nxt;
  logic [SEG_AW-1:0] loc;
  int                nphase, phase;
  logic [SLOT_W-1:0] last_slot;
  logic              boundary;

  always_comb begin
    case (mode_cur)
      2'b00:   nphase = NUM_PE;
      2'b01:   nphase = NUM_PE / 2;
      default: nphase = 1;
    endcase
    last_slot = SLOT_W'(nphase * SEG - 1);
  end

  assign phase     = int'(slot >> SEG_AW);
  assign loc       = slot[SEG_AW-1:0];
  assign iter_done = run && (slot == last_slot);
  assign boundary  = iter_done || (!run && slot == '0);
  assign pend_nxt  = (mode_wr && mode_req != 2'b11) ? mode_req : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      pend_q   <= 2'b00;
      mode_cur <= 2'b00;
    end else begin
      pend_q <= pend_nxt;
      if (boundary) mode_cur <= pend_nxt;
      if (run) slot <= iter_done ? '0 : slot + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    assign pe_active[k] = run && ((k % nphase) == phase);
    assign pe_sel[k*SEG_AW +: SEG_AW] = pe_active[k] ? loc : '0;
    for (genvar j = 0; j < SEG; j++) begin : g_reg
      assign reg_we[k*SEG+j] = pe_active[k] && (loc == SEG_AW'(j));
    end
  end

  a_r9_mode_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(mode_cur));

  a_r10_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(slot));

  a_r10_no_write_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (reg_we == '0));

  a_r7_done_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |=> !iter_done);

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |=> (slot == '0));

  a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cur != 2'b11);

  a_r5_all_active: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_cur == 2'b10) |-> (&pe_active));

  a_r3_single_active: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_cur == 2'b00) |-> ($countones(pe_active) == 1));

endmodule

// File: tb/pe_slot_sched_bench.sv
module pe_slot_sched_bench;
  localparam int NP  = 4;
  localparam int NR  = 16;
  localparam int SG  = NR / NP;
  localparam int SAW = $clog2(SG);
  localparam int SW  = $clog2(NR);

  logic clk = 0, rst_n = 0, run = 0, mode_wr = 0;
  logic [1:0] mode_req = 0;
  logic [1:0] mode_cur;
  logic [SW-1:0] slot;
  logic [NP-1:0] pe_active;
  logic [NP*SAW-1:0] pe_sel;
  logic [NR-1:0] reg_we;
  logic iter_done;

  pe_slot_sched #(.NUM_PE(NP), .NUM_REG(NR)) u_pe_slot_sched (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_wr(mode_wr), .mode_req(mode_req),
    .mode_cur(mode_cur), .slot(slot), .pe_active(pe_active), .pe_sel(pe_sel),
    .reg_we(reg_we), .iter_done(iter_done));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int m_mode = 0, m_pend = 0, m_slot = 0;
  int wc[NR];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nph(input int md);
    return md == 0 ? NP : (md == 1 ? NP / 2 : 1);
  endfunction

  function automatic logic [NP-1:0] exp_act(input int md, input int sl, input bit r);
    logic [NP-1:0] a = '0;
    for (int k = 0; k < NP; k++) a[k] = r && ((k % nph(md)) == sl / SG);
    return a;
  endfunction

  function automatic logic [NP*SAW-1:0] exp_sel(input logic [NP-1:0] a, input int sl);
    logic [NP*SAW-1:0] s = '0;
    for (int k = 0; k < NP; k++) if (a[k]) s[k*SAW +: SAW] = SAW'(sl % SG);
    return s;
  endfunction

  function automatic logic [NR-1:0] exp_we(input logic [NP-1:0] a, input int sl);
    logic [NR-1:0] w = '0;
    for (int k = 0; k < NP; k++) if (a[k]) w[k*SG + sl % SG] = 1'b1;
    return w;
  endfunction

  task automatic cyc(input bit r, input bit w, input logic [1:0] q);
    logic [NP-1:0] ea;
    bit ed;
    run = r; mode_wr = w; mode_req = q;
    #1;
    ea = exp_act(m_mode, m_slot, r);
    ed = r && (m_slot == nph(m_mode) * SG - 1);
    check(mode_cur == 2'(m_mode), "R9 mode_cur", mode_cur, m_mode);
    check(slot == SW'(m_slot), "R10 slot", slot, m_slot);
    check(pe_active == ea, "R3/R4/R5 pe_active", pe_active, ea);
    check(pe_sel == exp_sel(ea, m_slot), "R2 R11 pe_sel", pe_sel, exp_sel(ea, m_slot));
    check(reg_we == exp_we(ea, m_slot), "R2 reg_we", reg_we, exp_we(ea, m_slot));
    check(iter_done == ed, "R7 iter_done", iter_done, ed);
    for (int i = 0; i < NR; i++) wc[i] += int'(reg_we[i]);
    if (ed) begin
      for (int i = 0; i < NR; i++) begin
        check(wc[i] == 1, "R6 writes per iteration", wc[i], 1);
        wc[i] = 0;
      end
    end
    if (w && q != 2'b11) m_pend = int'(q);
    if (ed || (!r && m_slot == 0)) m_mode = m_pend;
    if (r) m_slot = ed ? 0 : m_slot + 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) wc[i] = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check(slot == '0, "R1 reset slot", slot, 0);
    check(mode_cur == 2'b00, "R1 reset mode", mode_cur, 0);
    check(iter_done == 1'b0, "R1 reset done", iter_done, 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(slot == '0 && mode_cur == 2'b00, "R1 after release", {mode_cur, slot}, 0);
    @(negedge clk);
    // R3: two full single-PE iterations
    repeat (2 * NR) cyc(1, 0, 0);
    // R9: strobe mid-iteration, mode must stay until boundary
    repeat (5) cyc(1, 0, 0);
    cyc(1, 1, 2'b01);
    check(mode_cur == 2'b00, "R9 held mid-iteration", mode_cur, 0);
    repeat (NR - 6) cyc(1, 0, 0);
    check(mode_cur == 2'b01, "R9 applied at boundary", mode_cur, 1);
    // R4: two-PE iterations, R8: reserved code ignored
    cyc(1, 1, 2'b11);
    repeat (2 * NR) cyc(1, 0, 0);
    check(mode_cur == 2'b01, "R8 reserved code ignored", mode_cur, 1);
    // R10: pause mid-iteration
    repeat (3) cyc(0, 0, 0);
    repeat (3) cyc(1, 0, 0);
    // R5: all-PE mode, with latest strobe winning (R9)
    cyc(1, 1, 2'b00);
    cyc(1, 1, 2'b10);
    repeat (4 * NR) cyc(1, 0, 0);
    check(mode_cur == 2'b10, "R5 all-PE mode reached", mode_cur, 2);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit r = ($urandom % 8) != 0;
      bit w = ($urandom % 12) == 0;
      cyc(r, w, 2'($urandom % 4));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule